// File: doc/BRIEF.md
# Dual-Output Waveform Timer Channel

This block is a single timer channel that produces two pulse-width-modulated outputs from one up-counter. The counter runs from 0 up to a period value and then wraps to 0. Each output compares the counter against its own compare value and shares the period match with the other output. Every output has a small action code for each of three events: its own compare match, the period match and a software trigger. This lets one counter produce two waveforms of any duty cycle and either polarity. Constant-high and constant-low levels come from a trigger action alone.

Software reaches the channel through a simple register port. There is a mode word, which holds the count-rate select and all six action fields. There are three compare values: output A, output B and the period. There is also a write-only command word that starts the clock, stops it, or restarts the waveform. The count rate is the main clock divided by 2, 8, 32 or 128, or a slow-clock enable pulse that arrives in the same clock domain.

Top module: `dual_wave_timer`

## Requirements
- R1: While the clock is running, each count tick raises the counter by one. On a tick taken when the counter equals the period register, the counter goes to 0 instead.
- R2: Mode bits [2:0] choose the count tick. Values 0, 1, 2 and 3 give one tick every 2, 8, 32 or 128 main-clock cycles. Values 4 to 7 give one tick for each cycle in which slow_tick is high.
- R3: Each action field is 2 bits: 00 leaves the output alone, 01 drives it high, 10 drives it low, 11 inverts it. Output A uses mode bits [5:4] on a compare-A match, [7:6] on a period match and [9:8] on a trigger. Output B uses [11:10], [13:12] and [15:14] in the same way.
- R4: A compare-A match acts only on output A, and a compare-B match acts only on output B.
- R5: When several events reach one output in the same cycle, only the highest one acts, even if its code is 00. The order from highest to lowest is trigger, then period match, then compare match.
- R6: Command bit 2 (trigger) clears the counter and the prescaler and applies each output's trigger action. It does this whether or not the clock is running.
- R7: Command bit 0 starts the clock and command bit 1 stops it; if both are set, the clock stops. While the clock is stopped, the counter and both outputs hold their values.
- R8: Writing command bit 0 clears the prescaler, so with divide-by-2 the counter first moves on the second edge after the write.
- R9: After reset both outputs are low, the counter is 0, the clock is stopped and the mode word reads 0.
- R10: Addresses 0 to 3 read back the mode word (bits [15:0], zero-extended), compare A, compare B and the period. Compare values keep their low counter-width bits. Address 4 is the command word, which reads as 0.
- R11: With every compare and period action set to 00, each output keeps the level left by the last trigger for as long as the counter runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow-clock enable pulse, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data for reg_addr (combinational) |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| count_out | output | CNT_W | Current counter value |

## Verification
The hardest cases to reach are coincident events. One is a compare value equal to the period, so that both events land on the same tick. The other is a trigger issued while the clock is stopped. The stimulus reaches the first by setting compare A equal to the period, with opposite actions on the two events. It reaches the second by stopping the clock and then issuing a bare trigger with a toggle action. A behavioural model follows the counter, the prescaler and both outputs every cycle. This exposes any difference in tick spacing or event priority at the first edge where it occurs.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_SET  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_TGL  = 2'b11
  } act_e;

  localparam int        ADDR_W = 3;
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CMPA = 3'd1;
  localparam logic [2:0] A_CMPB = 3'd2;
  localparam logic [2:0] A_PER  = 3'd3;
  localparam logic [2:0] A_CMD  = 3'd4;

  localparam int MODE_W       = 16;
  localparam int F_OUT_BASE   = 4;   // first action field of output A
  localparam int F_OUT_STRIDE = 6;   // distance to the fields of output B
  localparam int N_OUT        = 2;

  localparam int C_EN  = 0;
  localparam int C_DIS = 1;
  localparam int C_TRG = 2;

  localparam int PRE_W = 7;

  // new output level for an action code
  function automatic logic act_apply(input logic cur, input act_e a);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction

  // last prescaler value for divide-by 2 * 4^sel
  function automatic logic [PRE_W-1:0] div_last(input logic [1:0] sel);
    logic [7:0] d;
    d = 8'd2 << {sel, 1'b0};
    return PRE_W'(d - 8'd1);
  endfunction
endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [BUS_W-1:0]    rdata,
  output logic [MODE_W-1:0]   mode_q,
  output logic [CNT_W-1:0]    cmp_a_q,
  output logic [CNT_W-1:0]    cmp_b_q,
  output logic [CNT_W-1:0]    per_q,
  output logic                cmd_en,
  output logic                cmd_dis,
  output logic                cmd_trg
);
  logic wr_cmd;
  logic unused_hi;

  assign unused_hi = ^wdata[BUS_W-1:MODE_W];
  assign wr_cmd    = we && (addr == A_CMD);
  assign cmd_dis   = wr_cmd && wdata[C_DIS];
  assign cmd_en    = wr_cmd && wdata[C_EN] && !wdata[C_DIS];
  assign cmd_trg   = wr_cmd && wdata[C_TRG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      per_q   <= '0;
    end else if (we) begin
      case (addr)
        A_MODE:  mode_q  <= wdata[MODE_W-1:0];
        A_CMPA:  cmp_a_q <= wdata[CNT_W-1:0];
        A_CMPB:  cmp_b_q <= wdata[CNT_W-1:0];
        A_PER:   per_q   <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rdata = BUS_W'(mode_q);
      A_CMPA:  rdata = BUS_W'(cmp_a_q);
      A_CMPB:  rdata = BUS_W'(cmp_b_q);
      A_PER:   rdata = BUS_W'(per_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/wt_clkgen.sv
module wt_clkgen
  import wt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       slow_tick,
  input  logic       cmd_en,
  input  logic       cmd_dis,
  input  logic       cmd_trg,
  output logic       run_q,
  output logic       slow_sel,
  output logic       cnt_tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_last;
  logic             main_hit;

  assign slow_sel = clk_sel[2];
  assign pre_last = div_last(clk_sel[1:0]);
  assign main_hit = (pre_q >= pre_last);
  assign cnt_tick = run_q && (slow_sel ? slow_tick : main_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (cmd_dis) begin
      run_q <= 1'b0;
    end else if (cmd_en) begin
      run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (cmd_trg || cmd_en || !run_q || slow_sel) begin
      pre_q <= '0;
    end else begin
      pre_q <= main_hit ? '0 : pre_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             cmd_trg,
  input  logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             per_hit
);
  assign per_hit = cnt_tick && (cnt_q == per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cmd_trg) begin
      cnt_q <= '0;
    end else if (cnt_tick) begin
      cnt_q <= per_hit ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wt_wave_out.sv
module wt_wave_out
  import wt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trg_evt,
  input  logic per_evt,
  input  logic cmp_evt,
  input  act_e act_trg,
  input  act_e act_per,
  input  act_e act_cmp,
  output logic wave_q
);
  act_e sel_act;

  // trigger outranks period, period outranks compare
  always_comb begin
    if (trg_evt)      sel_act = act_trg;
    else if (per_evt) sel_act = act_per;
    else if (cmp_evt) sel_act = act_cmp;
    else              sel_act = ACT_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= act_apply(wave_q, sel_act);
  end
endmodule

// File: rtl/dual_wave_timer.sv
module dual_wave_timer
  import wt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              wave_a,
  output logic              wave_b,
  output logic [CNT_W-1:0]  count_out
);
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmp_a_q, cmp_b_q, period_q, cnt_q;
  logic              cmd_en, cmd_dis, sw_trig;
  logic              run_q, slow_sel, cnt_tick, per_hit;
  logic [CNT_W-1:0]  cmp_val [N_OUT];
  logic [N_OUT-1:0]  cmp_hit;
  logic [N_OUT-1:0]  wave_q;

  wt_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode_q(mode_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q),
    .per_q(period_q), .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(sw_trig)
  );

  wt_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n), .clk_sel(mode_q[2:0]), .slow_tick(slow_tick),
    .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(sw_trig),
    .run_q(run_q), .slow_sel(slow_sel), .cnt_tick(cnt_tick)
  );

  wt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cmd_trg(sw_trig),
    .per_q(period_q), .cnt_q(cnt_q), .per_hit(per_hit)
  );

  assign cmp_val[0] = cmp_a_q;
  assign cmp_val[1] = cmp_b_q;

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    localparam int BASE = F_OUT_BASE + g * F_OUT_STRIDE;
    assign cmp_hit[g] = cnt_tick && (cnt_q == cmp_val[g]);
    wt_wave_out u_wave (
      .clk(clk), .rst_n(rst_n),
      .trg_evt(sw_trig), .per_evt(per_hit), .cmp_evt(cmp_hit[g]),
      .act_trg(act_e'(mode_q[BASE+4 +: 2])),
      .act_per(act_e'(mode_q[BASE+2 +: 2])),
      .act_cmp(act_e'(mode_q[BASE +: 2])),
      .wave_q(wave_q[g])
    );
  end

  assign wave_a    = wave_q[0];
  assign wave_b    = wave_q[1];
  assign count_out = cnt_q;
endmodule

module wt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic             cnt_tick,
  input logic             sw_trig,
  input logic             slow_sel,
  input logic             slow_tick,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period_q,
  input logic [1:0]       wave_q
);
  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !sw_trig && cnt_q == period_q) |=> (cnt_q == '0));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !sw_trig && cnt_q != period_q) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R6
  trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> (cnt_q == '0));

  // R7
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !sw_trig) |=> ($stable(cnt_q) && $stable(wave_q)));

  // R7
  tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> run_q);

  // R2
  slow_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel && !slow_tick) |-> !cnt_tick);
endmodule

bind dual_wave_timer wt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_q(run_q), .cnt_tick(cnt_tick), .sw_trig(sw_trig),
  .slow_sel(slow_sel), .slow_tick(slow_tick), .cnt_q(cnt_q), .period_q(period_q),
  .wave_q(wave_q)
);

// File: tb/sim_dual_wave_timer.sv
module sim_dual_wave_timer;
  localparam int CLK_P = 10;
  localparam int CW    = 16;
  localparam int BW    = 32;
  localparam int CMASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0;
  wire  [BW-1:0] reg_rdata;
  wire           wave_a, wave_b;
  wire  [CW-1:0] count_out;

  int n_chk = 0;
  int n_bad = 0;

  dual_wave_timer u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_a(wave_a), .wave_b(wave_b), .count_out(count_out)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int m_mode = 0, m_ca = 0, m_cb = 0, m_per = 0, m_pre = 0, m_cnt = 0;
  bit m_run = 0, m_wa = 0, m_wb = 0;
  bit mon_en = 0;

  function automatic int fld(int pos);
    return (m_mode >> pos) & 3;
  endfunction

  function automatic bit next_lvl(bit cur, bit trg, bit ph, bit hc, int base);
    int a;
    if (trg)      a = fld(base + 4);
    else if (ph)  a = fld(base + 2);
    else if (hc)  a = fld(base);
    else          a = 0;
    case (a)
      1: return 1'b1;
      2: return 1'b0;
      3: return ~cur;
      default: return cur;
    endcase
  endfunction

  always @(posedge clk) begin : ref_model
    int sel, lastv;
    bit tk, wc, trg, dis, en, ph, ha, hb;
    if (!rst_n) begin
      m_mode = 0; m_ca = 0; m_cb = 0; m_per = 0; m_pre = 0; m_cnt = 0;
      m_run = 0; m_wa = 0; m_wb = 0;
    end else begin
      sel   = m_mode & 7;
      lastv = (2 << (2 * (sel & 3))) - 1;
      tk    = m_run && ((sel >= 4) ? slow_tick : (m_pre >= lastv));
      wc    = reg_we && (reg_addr == 3'd4);
      trg   = wc && reg_wdata[2];
      dis   = wc && reg_wdata[1];
      en    = wc && reg_wdata[0] && !dis;
      ph    = tk && (m_cnt == m_per);
      ha    = tk && (m_cnt == m_ca);
      hb    = tk && (m_cnt == m_cb);
      m_wa  = next_lvl(m_wa, trg, ph, ha, 4);
      m_wb  = next_lvl(m_wb, trg, ph, hb, 10);
      if (trg || en || !m_run || sel >= 4) m_pre = 0;
      else m_pre = (m_pre >= lastv) ? 0 : m_pre + 1;
      if (trg) m_cnt = 0;
      else if (tk) m_cnt = ph ? 0 : ((m_cnt + 1) & CMASK);
      if (dis) m_run = 0;
      else if (en) m_run = 1;
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_mode = int'(reg_wdata) & 'hFFFF;
          3'd1: m_ca   = int'(reg_wdata) & CMASK;
          3'd2: m_cb   = int'(reg_wdata) & CMASK;
          3'd3: m_per  = int'(reg_wdata) & CMASK;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      chk("R1 count vs model", count_out, m_cnt);
      chk("R3 wave_a vs model", wave_a, m_wa);
      chk("R3 wave_b vs model", wave_b, m_wb);
    end
  end

  // change trackers for the ignore/hold checks
  int a_chg = 0, b_chg = 0;
  bit pa = 0, pb = 0;
  always @(negedge clk) begin
    if (wave_a !== pa) a_chg++;
    if (wave_b !== pb) b_chg++;
    pa = wave_a;
    pb = wave_b;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [BW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input longint exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    wait_cyc(2);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin : watchdog
    #(CLK_P * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin : main
    int c;
    wait_cyc(4);
    // R9 reset state
    chk("R9 wave_a", wave_a, 0);
    chk("R9 wave_b", wave_b, 0);
    chk("R9 count", count_out, 0);
    rd_chk("R9 mode", 3'd0, 0);
    rst_n = 1'b1;
    mon_en = 1'b1;
    wait_cyc(1);

    // R10 readback
    wr(3'd1, 32'h1234_5678);
    rd_chk("R10 cmp_a", 3'd1, 'h5678);
    wr(3'd3, 32'd9);
    rd_chk("R10 period", 3'd3, 9);
    wr(3'd2, 32'd7);
    rd_chk("R10 cmp_b", 3'd2, 7);
    rd_chk("R10 command reads 0", 3'd4, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_chk("R10 mode width", 3'd0, 'hFFFF);
    wr(3'd0, 32'h0);

    // R8 first tick after enable, divide by 2
    wr(3'd3, 32'd3);
    wr(3'd4, 32'h1);
    wait_cyc(1);
    chk("R8 count after 1 edge", count_out, 0);
    wait_cyc(1);
    chk("R8 count after 2 edges", count_out, 1);
    wait_cyc(8);
    chk("R1 wrap at period", count_out, 1);

    // R7 disable holds counter
    wr(3'd4, 32'h2);
    #1 c = count_out;
    wait_cyc(10);
    chk("R7 counter held", count_out, c);

    // R6 trigger while stopped, toggle action on A
    wr(3'd0, 32'h300);
    wr(3'd4, 32'h4);
    chk("R6 count cleared", count_out, 0);
    chk("R6 wave_a toggled", wave_a, 1);
    wait_cyc(5);
    chk("R7 still stopped", count_out, 0);

    // R5 compare equals period: period action (clear) wins over compare (set)
    wr(3'd0, 32'h190);
    wr(3'd1, 32'd4);
    wr(3'd3, 32'd4);
    wr(3'd4, 32'h5);
    chk("R6 trigger set A", wave_a, 1);
    wait_cyc(30);
    chk("R5 period beats compare", wave_a, 0);

    // R3 normal polarity on A, inverted on B
    wr(3'd0, 32'hA560);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd6);
    wr(3'd3, 32'd9);
    wr(3'd4, 32'h4);
    chk("R3 A set by trigger", wave_a, 1);
    chk("R3 B cleared by trigger", wave_b, 0);
    wait_cyc(7);
    chk("R3 A before compare", wave_a, 1);
    wait_cyc(1);
    chk("R3 A cleared on compare", wave_a, 0);
    wait_cyc(6);
    chk("R3 B set on compare", wave_b, 1);
    wait_cyc(100);

    // R4 compare B toggles only B
    wr(3'd0, 32'hC00);
    wr(3'd2, 32'd2);
    wr(3'd3, 32'd5);
    wr(3'd4, 32'h4);
    #1 a_chg = 0; b_chg = 0;
    wait_cyc(60);
    #1;
    chk("R4 A untouched by compare B", a_chg, 0);
    chk("R4 B toggled by compare B", (b_chg >= 4), 1);

    // R11 constant levels from trigger only
    wr(3'd0, 32'h8100);
    wr(3'd4, 32'h4);
    #1 a_chg = 0; b_chg = 0;
    wait_cyc(80);
    #1;
    chk("R11 A held high", wave_a, 1);
    chk("R11 B held low", wave_b, 0);
    chk("R11 no edges", a_chg + b_chg, 0);

    // R2 slow tick source
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h4);
    wr(3'd3, 32'd100);
    wr(3'd4, 32'h5);
    wait_cyc(3);
    chk("R2 slow idle no count", count_out, 0);
    pulse_slow();
    pulse_slow();
    pulse_slow();
    chk("R2 slow pulses counted", count_out, 3);

    // R2 divide by 128
    wr(3'd0, 32'h3);
    wr(3'd4, 32'h5);
    wait_cyc(300);
    chk("R2 divide by 128", count_out, 2);

    // R7 enable and disable together: disable wins
    wr(3'd4, 32'h3);
    #1 c = count_out;
    wait_cyc(300);
    chk("R7 disable wins", count_out, c);

    summary();
    $finish;
  end
endmodule